// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Word-Width Fitting

This block receives a two-channel serial audio stream on three wires: a bit clock, a channel select line and a serial data line. It acts only as a clock slave. The bit clock and the channel select line come from the far end, and both are brought into the system clock domain through a synchronizer. Each rising edge of the bit clock takes one data bit, most significant bit first. The channel select line changes one bit period before the first bit of a word, so the bit sampled on the first rising edge that shows the new select value is the last bit of the word that is ending.

The sender does not know the width of the receiver. Each word is fitted to the fixed output width `OUT_W`. A word shorter than `OUT_W` is placed at the top of the output and its missing low bits are zero. A word longer than `OUT_W` keeps its top `OUT_W` bits and the rest are dropped. After a right-channel word completes, the block issues a single-cycle pulse that marks a full stereo frame on the two output registers.

The control is a four-state machine. `ST_PRIME` takes the first sample of the select line. `ST_HUNT` waits for the select line to fall, which marks the start of a left word. `ST_LEFT` and `ST_RIGHT` collect one word each. The transitions are: PRIME to HUNT on the first bit-clock rise; HUNT to LEFT on a falling select edge (a rising select edge leaves it in HUNT); LEFT to RIGHT on a rising select edge; RIGHT to LEFT on a falling select edge.

Top module: `i2s_rx_adapt`

## Requirements
- R1: After reset, `left_data` and `right_data` are zero and `frame_valid` is low.
- R2: Bits are sampled on bit-clock rising edges, most significant bit first. Select low means the left channel and select high means the right channel. A word ends with the bit sampled on the first rising edge at which the select line shows the other channel.
- R3: A word with fewer than `OUT_W` bits appears in the top bits of the output, and its low bits are zero.
- R4: A word with more than `OUT_W` bits keeps its first `OUT_W` bits, and every later bit of that word has no effect. The bit counter saturates at `OUT_W`.
- R5: A word of exactly `OUT_W` bits is output unchanged.
- R6: `frame_valid` is high for exactly one system clock when a right word completes after a left word. The outputs then hold that frame's left and right samples. One pulse is issued per frame.
- R7: After reset, nothing is latched and no pulse is issued until the select line has fallen. Partial words and right words before that point are discarded.
- R8: `left_data` changes only when a left word completes, and `right_data` changes only when a right word completes, together with the pulse.
- R9: The three inputs pass through `SYNC_STAGES` synchronizer flops. Each bit-clock rising edge yields exactly one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial bit clock from the sender |
| ws | input | 1 | Channel select: 0 left, 1 right |
| sd | input | 1 | Serial data, most significant bit first |
| left_data | output | OUT_W | Last completed left sample, fitted to OUT_W |
| right_data | output | OUT_W | Last completed right sample, fitted to OUT_W |
| frame_valid | output | 1 | One-cycle pulse when a stereo frame completes |

## Verification
The bench uses an 8-bit output and sends words of every length from 1 to 12 bits, four times each, with data patterns that differ for each frame. The stream starts with a partial left word and an orphan right word. A correct design must discard these, and a design that does not wait for the first falling select edge gives a pulse too many. Lengths below, equal to and above eight separate the zero-fill path, the plain path and the truncation path. Lengths of one and twelve test the ends of the counter. At the end, a left word is left open and then closed. This shows that the outputs move only when a word of their own channel completes.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_HUNT  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } rx_state_t;
endpackage

// File: rtl/i2srx_front.sv
module i2srx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ws,
    input  logic sd,
    output logic sck_rise,
    output logic ws_smp,
    output logic sd_smp
);
    localparam int LANES = 3;
    localparam int LAST  = SYNC_STAGES - 1;

    logic [LANES-1:0] chain [SYNC_STAGES];
    logic             sck_prev;

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= {sd, ws, sck};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= chain[LAST][0];
    end

    assign sck_rise = chain[LAST][0] & ~sck_prev;
    assign ws_smp   = chain[LAST][1];
    assign sd_smp   = chain[LAST][2];

    // R9: one sample per bit-clock rise, never on back-to-back system cycles
    a_r9_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);
endmodule

// File: rtl/i2srx_shift.sv
module i2srx_shift #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             sd,
    input  logic             word_end,
    output logic [OUT_W-1:0] word_now
);
    localparam int CNT_W = $clog2(OUT_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OUT_W);

    logic [OUT_W-1:0] acc;
    logic [CNT_W-1:0] cnt;

    // current word including the bit offered this cycle
    always_comb begin
        word_now = acc;
        for (int b = 0; b < OUT_W; b++) begin
            if (cnt == CNT_W'(OUT_W - 1 - b)) word_now[b] = sd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (bit_en) begin
            if (word_end) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= word_now;
                if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: counter never passes the output width
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);
    // R4: bits beyond the output width leave the accumulator untouched
    a_r4_excess_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !word_end && cnt == CNT_FULL) |=> $stable(acc));
    // R3: a new word starts from an all-zero accumulator
    a_r3_fresh_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && word_end) |=> (acc == '0 && cnt == '0));
endmodule

// File: rtl/i2srx_ctrl.sv
module i2srx_ctrl
    import i2srx_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             ws,
    input  logic [OUT_W-1:0] word_now,
    output logic             word_end,
    output logic [OUT_W-1:0] left_data,
    output logic [OUT_W-1:0] right_data,
    output logic             frame_valid
);
    rx_state_t state, state_nx;
    logic      ws_q;
    logic      ws_change;

    assign ws_change = bit_en && (ws != ws_q);
    assign word_end  = ws_change;

    always_ff @(posedge clk) begin
        if (!rst_n)      ws_q <= 1'b0;
        else if (bit_en) ws_q <= ws;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME: if (bit_en)               state_nx = ST_HUNT;
            ST_HUNT:  if (ws_change && !ws)     state_nx = ST_LEFT;
            ST_LEFT:  if (ws_change)            state_nx = ST_RIGHT;
            ST_RIGHT: if (ws_change)            state_nx = ST_LEFT;
            default:                            state_nx = ST_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_data   <= '0;
            right_data  <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (ws_change) begin
                unique case (state)
                    ST_LEFT:  left_data <= word_now;
                    ST_RIGHT: begin
                        right_data  <= word_now;
                        frame_valid <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: the pulse coincides with the start of the next left word
    a_r6_pulse_opens_left: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> state == ST_LEFT);
    // R6: one cycle wide
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    // R8: left sample moves only as a left word closes
    a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_data) |-> ($past(state) == ST_LEFT && state == ST_RIGHT));
    // R8: right sample moves only together with the frame pulse
    a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_data) |-> frame_valid);
    // R7: nothing is latched while still searching for alignment
    a_r7_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME || state == ST_HUNT) |=> $stable(left_data));
endmodule

// File: rtl/i2s_rx_adapt.sv
module i2s_rx_adapt #(
    parameter int OUT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             ws,
    input  logic             sd,
    output logic [OUT_W-1:0] left_data,
    output logic [OUT_W-1:0] right_data,
    output logic             frame_valid
);
    logic             sck_rise;
    logic             ws_smp;
    logic             sd_smp;
    logic             word_end;
    logic [OUT_W-1:0] word_now;

    i2srx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .ws       (ws),
        .sd       (sd),
        .sck_rise (sck_rise),
        .ws_smp   (ws_smp),
        .sd_smp   (sd_smp)
    );

    i2srx_shift #(.OUT_W(OUT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (sck_rise),
        .sd       (sd_smp),
        .word_end (word_end),
        .word_now (word_now)
    );

    i2srx_ctrl #(.OUT_W(OUT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (sck_rise),
        .ws          (ws_smp),
        .word_now    (word_now),
        .word_end    (word_end),
        .left_data   (left_data),
        .right_data  (right_data),
        .frame_valid (frame_valid)
    );
endmodule

// File: tb/sim_i2s_rx_adapt.sv
module sim_i2s_rx_adapt;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int HALF       = 4;
    localparam int NFRAMES    = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         ws = 1'b0;
    logic         sd = 1'b0;
    logic [W-1:0] left_data;
    logic [W-1:0] right_data;
    logic         frame_valid;

    int checks = 0;
    int fails  = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    logic [W-1:0] exp_l [64];
    logic [W-1:0] exp_r [64];
    int           exp_s [64];

    logic pend_b = 1'b0;
    bit   pend_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_rx_adapt #(.OUT_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
        .left_data(left_data), .right_data(right_data), .frame_valid(frame_valid)
    );

    function automatic logic [W-1:0] fit(logic [31:0] v, int s);
        logic [31:0] m;
        m = v & ((32'h1 << s) - 32'h1);
        if (s >= W) return W'(m >> (s - W));
        else        return W'(m << (W - s));
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // one bit period: data and select change while the clock is low
    task automatic drive_period(logic b, logic ch);
        @(negedge clk);
        sck = 1'b0; sd = b; ws = ch;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    // select leads data by one bit: the previous bit goes out with the new channel
    task automatic push(logic ch, logic b);
        if (pend_v) drive_period(pend_b, ch);
        pend_b = b;
        pend_v = 1'b1;
    endtask

    // frame monitor (R2, R3, R4, R5, R6, R9)
    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            if (pulse_cnt < NFRAMES) begin
                string tg;
                int s;
                s = exp_s[pulse_cnt];
                tg = (s < W) ? "R3" : (s > W) ? "R4" : "R5";
                chk($sformatf("R2 %s R6 left frame %0d len %0d", tg, pulse_cnt, s),
                    32'(left_data), 32'(exp_l[pulse_cnt]));
                chk($sformatf("R2 %s R6 right frame %0d len %0d", tg, pulse_cnt, s),
                    32'(right_data), 32'(exp_r[pulse_cnt]));
            end
            pulse_cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lv, rv;
        logic [W-1:0] last_l, last_r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 left after reset", 32'(left_data), 32'h0);
        chk("R1 right after reset", 32'(right_data), 32'h0);
        chk("R1 pulse after reset", 32'(frame_valid), 32'h0);

        // R7: partial left word, then an orphan right word
        for (int i = 0; i < 5; i++) push(1'b0, 1'(i & 1));
        for (int i = 0; i < 9; i++) push(1'b1, 1'b1);
        repeat (8) @(negedge clk);
        chk("R7 no pulse before alignment", 32'(pulse_cnt), 32'h0);
        chk("R7 left untouched before alignment", 32'(left_data), 32'h0);
        chk("R7 right untouched before alignment", 32'(right_data), 32'h0);

        // sweep of word lengths 1..12 with varied data
        for (int k = 0; k < NFRAMES; k++) begin
            int s;
            s  = 1 + (k % 12);
            lv = 32'hB4E1_6A3D ^ (32'(k) * 32'h0101_0137);
            rv = {lv[15:0], lv[31:16]} ^ 32'h5A5A_F00F ^ 32'(k);
            exp_s[k] = s;
            exp_l[k] = fit(lv, s);
            exp_r[k] = fit(rv, s);
            for (int i = s - 1; i >= 0; i--) push(1'b0, lv[i]);
            for (int i = s - 1; i >= 0; i--) push(1'b1, rv[i]);
        end
        last_l = exp_l[NFRAMES-1];
        last_r = exp_r[NFRAMES-1];

        // open a left word; the final right word closes with its first bit
        lv = 32'h0000_00C6;
        for (int i = W - 1; i >= 0; i--) push(1'b0, lv[i]);
        repeat (8) @(negedge clk);
        chk("R6 one pulse per frame", 32'(pulse_cnt), 32'(NFRAMES));
        chk("R8 left holds while left word open", 32'(left_data), 32'(last_l));

        // close the left word with a right bit
        push(1'b1, 1'b0);
        repeat (8) @(negedge clk);
        chk("R8 left updates on left completion", 32'(left_data), 32'(fit(lv, W)));
        chk("R8 right holds without right completion", 32'(right_data), 32'(last_r));
        chk("R6 no pulse on left completion", 32'(pulse_cnt), 32'(NFRAMES));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule